// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Frame Engine

This block is the master-side shifter and framer of a synchronous serial port. It takes a parallel word from an upstream ready/valid source and sends it out serially, most significant bit first. It drives the bit clock and the frame signal, and it samples the serial input. Received bits are gathered into a right-aligned word, which is presented with a one-cycle valid strobe. A separate rate generator supplies single-cycle rise and fall enables. The engine raises `xfer_active` to request them and expects them to alternate, starting with a rise.

Three frame formats can be selected:

- **SPI-style** is full duplex. The frame signal is a low level held for the whole frame.
- **TI-style** is full duplex. The frame signal is a one-clock high pulse ahead of the data.
- **Microwire-style** is half duplex. It sends an 8-bit command, then spends one turnaround clock, then receives a reply of programmable length.

The format and word size are captured when a word is accepted. They hold for the whole frame.

Top module: `sync_frame_engine`

## Requirements
- R1: After reset the engine is idle: `tx_ready`=1, `xfer_active`=0, `sclk`=0, `sdo`=0, `rx_valid`=0. `frame_out` sits at its idle level, which is 1 unless the TI-style format is selected (then 0).
- R2: `size_m1` holds the word length minus one. Values 3..15 give 4..16 bits, and values 0..2 are treated as 4 bits. Data leaves and arrives most significant bit first.
- R3: SPI-style format (`fmt_sel`=00):
  - `frame_out` is 0 during every clock of the frame.
  - The first bit is on `sdo` before the first rising edge, and later bits change on falling edges.
  - `sdi` is sampled on each rising edge, and the frame has exactly N clocks.
- R4: TI-style format (`fmt_sel`=01):
  - `frame_out` is 1 for the first clock only, from its rising edge to the next rising edge.
  - Each of the following N rising edges puts the next data bit on `sdo`, and `sdi` is sampled on each falling edge.
  - The frame has N+1 clocks.
- R5: Microwire-style format (`fmt_sel`=10):
  - The low 8 bits of `tx_word` go out first as the command, over 8 clocks with no input captured.
  - One turnaround clock follows. Then N reply bits are sampled on rising edges, for 9+N clocks in all.
  - `sdo` is 0 after the command.
- R6: `sclk` toggles only while `xfer_active` is 1 and rests at 0 otherwise. `sdo` is 0 while idle.
- R7: A word is accepted in a cycle where `tx_valid` and `tx_ready` are both 1. `xfer_active` is 1 from the next cycle until the frame's final falling edge, and `tx_ready` is its inverse.
- R8: `rx_word` holds the N captured bits right-aligned, with the upper bits zero. `rx_valid` is a one-cycle pulse in the cycle after the edge that samples the last bit.
- R9: Changing `fmt_sel` or `size_m1` during a frame has no effect on that frame.
- R10: If `tx_valid` is held while a frame runs, the next frame is accepted in the cycle after `xfer_active` falls. Exactly one idle cycle separates the two frames.
- R11: `fmt_sel`=11 behaves as the SPI-style format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Frame format: 00 SPI, 01 TI, 10 Microwire, 11 SPI |
| size_m1 | input | 4 | Word length minus one |
| tx_word | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Engine can accept a word |
| rx_word | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |
| bclk_rise | input | 1 | Rise enable from the rate generator |
| bclk_fall | input | 1 | Fall enable from the rate generator |
| xfer_active | output | 1 | Frame in progress; requests enables |
| sclk | output | 1 | Serial bit clock |
| frame_out | output | 1 | Frame signal |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Every output is a register updated on the enable edge that moves it, so each serial event is visible one system cycle after the enable that causes it. The bench samples on the falling system clock and detects `sclk` edges by comparing with the previous sample. At those points it records `sdo` and the frame level, and it drives the next `sdi` bit half a system cycle ahead of the edge that samples it.

`rx_valid` is due in exactly the sample where the last sampling edge first shows up: a rising edge for the SPI and Microwire formats, a falling edge for the TI format. The monitor raises its own expected strobe at that point and compares the two in every cycle where either is high.

The clock count and the idle levels are checked in the sample where `xfer_active` drops. The single idle cycle between back-to-back frames is counted in samples.

// File: rtl/sync_frame_engine.sv
module sync_frame_engine #(
  parameter int DMAX = 16,
  parameter int CMDW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      fmt_sel,
  input  logic [3:0]      size_m1,
  input  logic [DMAX-1:0] tx_word,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [DMAX-1:0] rx_word,
  output logic            rx_valid,
  input  logic            bclk_rise,
  input  logic            bclk_fall,
  output logic            xfer_active,
  output logic            sclk,
  output logic            frame_out,
  output logic            sdo,
  input  logic            sdi
);
  localparam int SW   = $clog2(DMAX);
  localparam int NW   = SW + 1;
  localparam int CNTW = $clog2(CMDW + DMAX + 1);
  localparam logic [1:0] F_TI = 2'b01;
  localparam logic [1:0] F_MW = 2'b10;

  logic            run, sclk_q, sdo_q, tip_q, rxv_q;
  logic [1:0]      fmt_q;
  logic [NW-1:0]   n_q;
  logic [CNTW-1:0] slot;
  logic [DMAX-1:0] txs, rxs, rx_q;

  wire is_ti   = (fmt_q == F_TI);
  wire is_mw   = (fmt_q == F_MW);
  wire rise_ev = run & bclk_rise;
  wire fall_ev = run & bclk_fall;
  wire accept  = tx_valid & ~run;

  wire [NW-1:0] n_in = (size_m1 < SW'(3)) ? NW'(4) : ({1'b0, size_m1} + NW'(1));

  wire [DMAX-1:0] ld_word = (fmt_sel == F_MW)
                          ? {tx_word[CMDW-1:0], {(DMAX-CMDW){1'b0}}}
                          : (tx_word << (DMAX - int'(n_in)));

  wire [CNTW-1:0] last_slot = is_mw ? (CNTW'(CMDW) + CNTW'(n_q))
                            : is_ti ? CNTW'(n_q)
                            : (CNTW'(n_q) - CNTW'(1));

  wire samp = (rise_ev & ~is_ti & (~is_mw | (slot > CNTW'(CMDW))))
            | (fall_ev & is_ti & (slot != '0));
  wire last_samp = samp & (slot == last_slot);
  wire done      = fall_ev & (slot == last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      fmt_q  <= '0;
      n_q    <= NW'(4);
      slot   <= '0;
      txs    <= '0;
      rxs    <= '0;
      rx_q   <= '0;
      rxv_q  <= 1'b0;
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
      tip_q  <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (accept) begin
        run   <= 1'b1;
        fmt_q <= fmt_sel;
        n_q   <= n_in;
        slot  <= '0;
        rxs   <= '0;
        tip_q <= 1'b0;
        if (fmt_sel == F_TI) begin
          txs   <= ld_word;
          sdo_q <= 1'b0;
        end else begin
          txs   <= ld_word << 1;
          sdo_q <= ld_word[DMAX-1];
        end
      end else if (run) begin
        if (rise_ev) begin
          sclk_q <= 1'b1;
          if (is_ti) begin
            tip_q <= (slot == '0);
            if (slot != '0) begin
              sdo_q <= txs[DMAX-1];
              txs   <= txs << 1;
            end
          end
        end
        if (fall_ev) begin
          sclk_q <= 1'b0;
          slot   <= slot + CNTW'(1);
          if (!is_ti) begin
            sdo_q <= txs[DMAX-1];
            txs   <= txs << 1;
          end
        end
        if (samp) rxs <= {rxs[DMAX-2:0], sdi};
        if (last_samp) begin
          rx_q  <= {rxs[DMAX-2:0], sdi};
          rxv_q <= 1'b1;
        end
        if (done) begin
          run   <= 1'b0;
          sdo_q <= 1'b0;
          tip_q <= 1'b0;
        end
      end
    end
  end

  assign tx_ready    = ~run;
  assign xfer_active = run;
  assign sclk        = sclk_q;
  assign sdo         = sdo_q;
  assign rx_word     = rx_q;
  assign rx_valid    = rxv_q;
  assign frame_out   = run ? (is_ti & tip_q) : (fmt_sel != F_TI);

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !sclk);
  p_sdo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !sdo);
  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_rx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_word >> n_q) == '0));
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(fmt_q) && $stable(n_q)));
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (xfer_active && !tx_ready));
endmodule

// File: tb/sync_frame_engine_bench.sv
module sync_frame_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt_sel = 2'b00;
  logic [3:0] size_m1 = 4'd7;
  logic [15:0] tx_word = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, rx_valid, xfer_active, sclk, frame_out, sdo;
  logic [15:0] rx_word;
  logic bclk_rise = 1'b0, bclk_fall = 1'b0;
  logic sdi = 1'b0;

  always #2.5 clk = ~clk;

  sync_frame_engine u_sync_frame_engine (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .size_m1(size_m1),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_word(rx_word), .rx_valid(rx_valid), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .xfer_active(xfer_active), .sclk(sclk),
    .frame_out(frame_out), .sdo(sdo), .sdi(sdi));

  typedef struct packed {
    logic [1:0]  fmt;
    logic [4:0]  n;
    logic [15:0] word;
    logic [15:0] reply;
    logic        b2b;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] f);
    if (f == 2'b01) return "R4";
    if (f == 2'b10) return "R5";
    if (f == 2'b11) return "R11";
    return "R3";
  endfunction

  // rate generator: alternating rise then fall enables while a frame runs
  int gcnt = 0;
  always @(negedge clk) begin
    if (!xfer_active) begin
      gcnt = 0; bclk_rise = 1'b0; bclk_fall = 1'b0;
    end else begin
      bclk_rise = (gcnt == 1);
      bclk_fall = (gcnt == 3);
      gcnt = (gcnt + 1) % 4;
    end
  end

  // monitor / slave model
  item_t cur;
  bit    have = 0;
  bit    prev_act = 0, prev_sclk = 0;
  int    rises = 0, gap = 0, frm_bad = 0, tail_bad = 0, nb;
  logic [15:0] got;
  bit    ev;
  always @(negedge clk) begin
    ev = 0;
    if (rst_n) begin
      if (xfer_active && !prev_act) begin
        if (q.size() == 0) begin
          chk(0, "R7", "frame started with nothing queued", 1, 0);
        end else begin
          cur = q.pop_front(); have = 1;
          rises = 0; got = '0; frm_bad = 0; tail_bad = 0; nb = int'(cur.n);
          chk(!tx_ready, "R7", "tx_ready during frame", tx_ready, 0);
          if (cur.b2b) chk(gap == 1, "R10", "idle cycles between frames", gap, 1);
          if (cur.fmt == 2'b10) sdi = 1'b1;
          else if (cur.fmt == 2'b01) sdi = 1'b0;
          else sdi = cur.reply[nb-1];
        end
      end
      if (have && sclk && !prev_sclk) begin
        if (cur.fmt == 2'b01) begin
          if (frame_out != (rises == 0)) frm_bad++;
          if (rises >= 1) begin
            got = {got[14:0], sdo};
            if (rises <= nb) sdi = cur.reply[nb-rises];
          end
        end else begin
          if (frame_out != 1'b0) frm_bad++;
          if (cur.fmt == 2'b10) begin
            if (rises < 8) got = {got[14:0], sdo};
            else if (sdo) tail_bad++;
            if (rises == 8 + nb) ev = 1;
          end else begin
            got = {got[14:0], sdo};
            if (rises == nb - 1) ev = 1;
          end
        end
        rises++;
      end
      if (have && !sclk && prev_sclk) begin
        if (cur.fmt == 2'b01) begin
          if (rises - 1 == nb) ev = 1;
        end else if (cur.fmt == 2'b10) begin
          if (rises - 1 >= 8 && rises - 9 < nb) sdi = cur.reply[nb-1-(rises-9)];
          else sdi = 1'b1;
        end else begin
          if (rises < nb) sdi = cur.reply[nb-1-rises];
        end
      end
      if (rx_valid || ev) begin
        chk(rx_valid == ev, "R8", "rx_valid timing", rx_valid, ev);
        if (rx_valid && have)
          chk(rx_word == cur.reply, req_of(cur.fmt), "received word (R8 aligned)",
              rx_word, cur.reply);
      end
      if (!xfer_active && prev_act && have) begin
        int exp_clk;
        logic [15:0] exp_tx;
        if (cur.fmt == 2'b01) exp_clk = nb + 1;
        else if (cur.fmt == 2'b10) exp_clk = 9 + nb;
        else exp_clk = nb;
        exp_tx = (cur.fmt == 2'b10) ? {8'h00, cur.word[7:0]}
                                    : (cur.word & 16'((32'h1 << nb) - 1));
        chk(rises == exp_clk, req_of(cur.fmt), "bit clock count", rises, exp_clk);
        chk(got == exp_tx, req_of(cur.fmt), "serial bits sent (R2 msb first)", got, exp_tx);
        chk(frm_bad == 0, req_of(cur.fmt), "frame signal level at clocks", frm_bad, 0);
        if (cur.fmt == 2'b10) chk(tail_bad == 0, "R5", "sdo after command", tail_bad, 0);
        chk(!sclk && !sdo, "R6", "sclk/sdo idle after frame", {sclk, sdo}, 0);
        chk(frame_out == (fmt_sel != 2'b01), "R6", "frame idle level", frame_out,
            (fmt_sel != 2'b01));
        have = 0;
      end
      if (xfer_active) gap = 0; else gap++;
      prev_act = xfer_active;
      prev_sclk = sclk;
    end
  end

  task automatic send(input logic [1:0] f, input logic [3:0] d, input logic [15:0] w,
                      input logic [15:0] r, input bit scramble, input bit b2b,
                      input bit hold);
    item_t it;
    int n;
    n = (d < 3) ? 4 : int'(d) + 1;
    fmt_sel = f; size_m1 = d; tx_word = w; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    it.fmt = f; it.n = 5'(n); it.word = w;
    it.reply = r & 16'((32'h1 << n) - 1); it.b2b = b2b;
    q.push_back(it);
    @(negedge clk);
    if (!hold) tx_valid = 1'b0;
    if (scramble) begin
      fmt_sel = ~f; size_m1 = ~d;
    end
  endtask

  task automatic drain();
    while (q.size() != 0 || xfer_active || have) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk);
    chk(tx_ready && !xfer_active && !sclk && !sdo && !rx_valid && frame_out,
        "R1", "reset state", {tx_ready, xfer_active, sclk, sdo, rx_valid, frame_out},
        6'b100001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready && !xfer_active && frame_out, "R1", "idle after reset",
        {tx_ready, xfer_active, frame_out}, 3'b101);
    fmt_sel = 2'b01;
    @(negedge clk);
    chk(frame_out == 1'b0, "R1", "TI idle frame level", frame_out, 0);

    send(2'b00, 4'd7,  16'h00A5, 16'h003C, 0, 0, 0); drain();
    send(2'b00, 4'd3,  16'h00F9, 16'h0006, 0, 0, 0); drain();
    send(2'b00, 4'd15, 16'h8001, 16'hBEEF, 0, 0, 0); drain();
    send(2'b00, 4'd1,  16'hFFFA, 16'hFFF5, 0, 0, 0); drain();   // R2 clamp to 4 bits
    send(2'b01, 4'd7,  16'h005A, 16'h00C3, 0, 0, 0); drain();
    send(2'b01, 4'd15, 16'hF00D, 16'h1234, 0, 0, 0); drain();
    send(2'b01, 4'd4,  16'h0013, 16'h000E, 0, 0, 0); drain();
    send(2'b10, 4'd7,  16'h1234, 16'h00C3, 0, 0, 0); drain();
    send(2'b10, 4'd3,  16'hFF81, 16'h0009, 0, 0, 0); drain();
    send(2'b10, 4'd15, 16'h00E7, 16'hA55A, 0, 0, 0); drain();
    send(2'b11, 4'd11, 16'h0ABC, 16'h0555, 0, 0, 0); drain();   // R11
    send(2'b00, 4'd7,  16'h0096, 16'h0069, 1, 0, 0); drain();   // R9
    send(2'b01, 4'd9,  16'h02D3, 16'h0155, 1, 0, 0); drain();   // R9
    send(2'b10, 4'd5,  16'h004B, 16'h002A, 1, 0, 0); drain();   // R9
    send(2'b00, 4'd7,  16'h0011, 16'h0022, 0, 0, 1);            // R10 chain
    send(2'b00, 4'd7,  16'h0033, 16'h0044, 0, 1, 1);
    send(2'b01, 4'd5,  16'h0015, 16'h002A, 0, 1, 1);
    send(2'b10, 4'd3,  16'h0081, 16'h0007, 0, 1, 0);
    drain();
    finished = 1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "R7", "watchdog expired", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule